// File: doc/BRIEF.md
# PCI Target Latency Timeout Monitor

This block watches how quickly a target answers on a PCI-style bus. When a transaction begins, it counts clock edges until the first data phase completes and compares the count with an initial limit. Inside a burst, it restarts the count after each completed data phase and compares it with a shorter subsequent limit. When a limit is exceeded, the block issues a one-cycle request to terminate the bus cycle and sets a timeout flag. The protocol engine that owns the bus acts on that request.

The initial limit comes from a two-bit select. An alternate-table bit chooses between two decodings of that select: a short table and a long table. The long table includes a setting that turns the initial timeout off. The subsequent limit comes from a one-bit select. All three selects are captured when a transaction starts. Changing them during a transaction has no effect until the next one.

A separate tenure timer counts clock edges while the block owns the bus. It raises an expiry flag when the count reaches a programmed value whose three low bits are forced to zero. The flag drops when ownership ends.

Top module: `pci_lat_watch`

## Requirements
- R1: While reset is held, and in the first cycle after it, `term_req`, `lat_timeout` and `tenure_exp` are 0.
- R2: With `cfg_alt_tbl`=0, `cfg_init_sel` 00/01/10/11 gives an initial limit L of 32/16/8/4. If no data phase completes, `term_req` is high in the cycle after the L-th clock edge that follows the edge sampling `txn_start`. It is low after every earlier edge.
- R3: With `cfg_alt_tbl`=1, `cfg_init_sel` 00/01/10 gives L of 64/128/256 with the same timing as R2. Code 11 disables the initial timeout, so `term_req` never rises while the transaction waits for its first data phase.
- R4: After a data phase completes, the limit is S=8 when `cfg_sub_sel`=0 and S=4 when it is 1. `term_req` is high after the S-th edge that follows the edge sampling `data_done`, if no further data phase completes.
- R5: A completed data phase (`data_done` high at an edge) clears the count, produces no termination in that cycle, and switches the block to the subsequent limit.
- R6: `term_req` lasts exactly one cycle. `lat_timeout` rises together with it and stays high until the next `txn_start`, which clears it. After a termination the count stays idle until a new `txn_start`.
- R7: `txn_end` stops the count without a termination. No `term_req` follows until the next `txn_start`.
- R8: `cfg_alt_tbl`, `cfg_init_sel` and `cfg_sub_sel` are sampled only at the edge that sees `txn_start`. Later changes leave the limits of the running transaction unchanged.
- R9: The tenure limit T is `cfg_tenure` with bits [2:0] taken as zero, captured on the first cycle `bus_own` is high. `tenure_exp` is high after the (T+1)-th edge with `bus_own` high, counting the capturing edge, and stays high while `bus_own` remains high. The low bits and later changes of `cfg_tenure` have no effect.
- R10: An edge with `bus_own` low clears `tenure_exp` and the tenure count.
- R11: A `txn_start` during a running transaction restarts the count with the newly sampled configuration. It has priority over `txn_end` and `data_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alt_tbl | input | 1 | Selects the long initial-limit table |
| cfg_init_sel | input | 2 | Initial latency limit code |
| cfg_sub_sel | input | 1 | Subsequent latency limit code |
| cfg_tenure | input | TEN_W | Tenure timer value, low three bits ignored |
| txn_start | input | 1 | Transaction begins (one-cycle event) |
| data_done | input | 1 | A data phase completed this cycle |
| txn_end | input | 1 | Transaction finished normally |
| bus_own | input | 1 | High while the block holds the bus grant |
| term_req | output | 1 | One-cycle request to terminate the bus cycle |
| lat_timeout | output | 1 | Sticky flag: the last transaction timed out |
| tenure_exp | output | 1 | Tenure timer reached its limit |

## Verification
The bench builds the block with its default parameters: an 8-bit tenure value with three masked low bits. The widest limits, 256 edges and a 248-edge tenure, stay within the cycle budget, so every table entry can be exercised to its exact firing edge, including the disabled setting. Random transactions draw each phase delay from a range that reaches two edges past the limit, so both sides of every boundary are covered. During a transaction the configuration inputs are re-randomised on every cycle, so a limit that is sampled at the wrong time shows up as a wrong firing edge.

// File: rtl/pci_lat_pkg.sv
package pci_lat_pkg;

  // Base values of the limit tables, in clock edges.
  localparam int unsigned SUB_LONG  = 8;
  localparam int unsigned INIT_BASE = 32;
  localparam int unsigned ALT_BASE  = 64;
  localparam int unsigned LIM_W     = $clog2((ALT_BASE << 2) + 1);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_NEXT  = 2'd2
  } phase_e;

  typedef struct packed {
    logic             none;
    logic [LIM_W-1:0] edges;
  } lim_t;

  // Short table halves from INIT_BASE, long table doubles from ALT_BASE.
  function automatic lim_t init_limit(input logic alt, input logic [1:0] sel);
    lim_t r;
    r.none  = 1'b0;
    r.edges = '0;
    if (!alt) begin
      r.edges = LIM_W'(INIT_BASE >> sel);
    end else if (sel == 2'b11) begin
      r.none = 1'b1;
    end else begin
      r.edges = LIM_W'(ALT_BASE << sel);
    end
    return r;
  endfunction

  function automatic lim_t sub_limit(input logic sel);
    lim_t r;
    r.none  = 1'b0;
    r.edges = sel ? LIM_W'(SUB_LONG / 2) : LIM_W'(SUB_LONG);
    return r;
  endfunction

endpackage

// File: rtl/lat_limit_sel.sv
module lat_limit_sel
  import pci_lat_pkg::*;
(
  input  logic       alt_tbl,
  input  logic [1:0] init_sel,
  input  logic       sub_sel,
  output lim_t       init_lim,
  output lim_t       sub_lim
);

  always_comb begin
    init_lim = init_limit(alt_tbl, init_sel);
    sub_lim  = sub_limit(sub_sel);
  end

endmodule

// File: rtl/lat_phase_ctr.sv
module lat_phase_ctr
  import pci_lat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_start,
  input  logic             txn_end,
  input  logic             data_done,
  input  lim_t             init_lim_in,
  input  lim_t             sub_lim_in,
  output logic             term_req,
  output logic             lat_timeout,
  output phase_e           phase,
  output logic [LIM_W-1:0] cnt,
  output lim_t             cur_lim,
  output logic             fire
);

  lim_t init_q;
  lim_t sub_q;
  logic active;

  assign active  = (phase != PH_IDLE);
  assign cur_lim = (phase == PH_FIRST) ? init_q : sub_q;

  // Fire on the edge whose count would reach the limit.
  always_comb begin
    fire = 1'b0;
    if (active && !txn_start && !txn_end && !data_done && !cur_lim.none)
      fire = (cnt == cur_lim.edges - LIM_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      init_q      <= '0;
      sub_q       <= '0;
      term_req    <= 1'b0;
      lat_timeout <= 1'b0;
    end else begin
      term_req <= fire;
      if (txn_start) begin
        init_q      <= init_lim_in;
        sub_q       <= sub_lim_in;
        phase       <= PH_FIRST;
        cnt         <= '0;
        lat_timeout <= 1'b0;
      end else if (active) begin
        if (txn_end) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else if (data_done) begin
          phase <= PH_NEXT;
          cnt   <= '0;
        end else if (fire) begin
          phase       <= PH_IDLE;
          cnt         <= '0;
          lat_timeout <= 1'b1;
        end else if (!cur_lim.none) begin
          cnt <= cnt + LIM_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/tenure_timer.sv
module tenure_timer #(
  parameter int unsigned TEN_W    = 8,
  parameter int unsigned MASK_LSB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_own,
  input  logic [TEN_W-1:0] cfg_val,
  output logic             expired,
  output logic [TEN_W-1:0] cnt,
  output logic [TEN_W-1:0] lim_eff
);

  logic             own_q;
  logic             own_rise;
  logic [TEN_W-1:0] lim_q;
  logic [TEN_W-1:0] lim_mask;

  assign own_rise = bus_own && !own_q;
  assign lim_mask = {cfg_val[TEN_W-1:MASK_LSB], {MASK_LSB{1'b0}}};
  assign lim_eff  = own_rise ? lim_mask : lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q   <= 1'b0;
      lim_q   <= '0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      own_q <= bus_own;
      if (!bus_own) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else begin
        if (own_rise) lim_q <= lim_mask;
        if (cnt != {TEN_W{1'b1}}) cnt <= cnt + TEN_W'(1);
        if (cnt == lim_eff) expired <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pci_lat_watch.sv
module pci_lat_watch
  import pci_lat_pkg::*;
#(
  parameter int unsigned TEN_W    = 8,
  parameter int unsigned MASK_LSB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_alt_tbl,
  input  logic [1:0]       cfg_init_sel,
  input  logic             cfg_sub_sel,
  input  logic [TEN_W-1:0] cfg_tenure,
  input  logic             txn_start,
  input  logic             data_done,
  input  logic             txn_end,
  input  logic             bus_own,
  output logic             term_req,
  output logic             lat_timeout,
  output logic             tenure_exp
);

  lim_t             init_lim_w;
  lim_t             sub_lim_w;
  phase_e           phase_w;
  logic [LIM_W-1:0] cnt_w;
  lim_t             cur_lim_w;
  logic             fire_w;
  logic [TEN_W-1:0] ten_cnt_w;
  logic [TEN_W-1:0] ten_lim_w;

  lat_limit_sel u_sel (
    .alt_tbl  (cfg_alt_tbl),
    .init_sel (cfg_init_sel),
    .sub_sel  (cfg_sub_sel),
    .init_lim (init_lim_w),
    .sub_lim  (sub_lim_w)
  );

  lat_phase_ctr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .txn_end     (txn_end),
    .data_done   (data_done),
    .init_lim_in (init_lim_w),
    .sub_lim_in  (sub_lim_w),
    .term_req    (term_req),
    .lat_timeout (lat_timeout),
    .phase       (phase_w),
    .cnt         (cnt_w),
    .cur_lim     (cur_lim_w),
    .fire        (fire_w)
  );

  tenure_timer #(
    .TEN_W    (TEN_W),
    .MASK_LSB (MASK_LSB)
  ) u_ten (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_own (bus_own),
    .cfg_val (cfg_tenure),
    .expired (tenure_exp),
    .cnt     (ten_cnt_w),
    .lim_eff (ten_lim_w)
  );

endmodule

// File: rtl/pci_lat_watch_chk.sv
module pci_lat_watch_chk
  import pci_lat_pkg::*;
#(
  parameter int unsigned TEN_W    = 8,
  parameter int unsigned MASK_LSB = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_start,
  input logic             data_done,
  input logic             txn_end,
  input logic             bus_own,
  input logic             term_req,
  input logic             lat_timeout,
  input logic             tenure_exp,
  input phase_e           phase_w,
  input logic [LIM_W-1:0] cnt_w,
  input lim_t             cur_lim_w,
  input logic             fire_w,
  input logic [TEN_W-1:0] ten_cnt_w,
  input logic [TEN_W-1:0] ten_lim_w
);

  assert_term_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> !term_req);

  assert_term_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> (lat_timeout && phase_w == PH_IDLE));

  assert_cnt_below_lim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w != PH_IDLE && !cur_lim_w.none) |-> (cnt_w < cur_lim_w.edges));

  assert_none_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w != PH_IDLE && cur_lim_w.none) |=> !term_req);

  assert_data_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w != PH_IDLE && data_done && !txn_start && !txn_end)
      |=> (cnt_w == '0 && phase_w == PH_NEXT && !term_req));

  assert_end_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !txn_start) |=> (phase_w == PH_IDLE && !term_req));

  assert_start_arms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> (phase_w == PH_FIRST && cnt_w == '0 && !lat_timeout));

  assert_tenure_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |=> (!tenure_exp && ten_cnt_w == '0));

  assert_tenure_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tenure_exp) |-> (ten_lim_w[MASK_LSB-1:0] == '0 && $past(bus_own)));

  assert_fire_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w == PH_IDLE) |-> !fire_w);

endmodule

bind pci_lat_watch pci_lat_watch_chk #(
  .TEN_W    (TEN_W),
  .MASK_LSB (MASK_LSB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txn_start   (txn_start),
  .data_done   (data_done),
  .txn_end     (txn_end),
  .bus_own     (bus_own),
  .term_req    (term_req),
  .lat_timeout (lat_timeout),
  .tenure_exp  (tenure_exp),
  .phase_w     (phase_w),
  .cnt_w       (cnt_w),
  .cur_lim_w   (cur_lim_w),
  .fire_w      (fire_w),
  .ten_cnt_w   (ten_cnt_w),
  .ten_lim_w   (ten_lim_w)
);

// File: tb/test_pci_lat_watch.sv
module test_pci_lat_watch;

  localparam int CLK_PERIOD = 10;
  localparam int TEN_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_alt_tbl = 1'b0;
  logic [1:0]       cfg_init_sel = 2'b00;
  logic             cfg_sub_sel = 1'b0;
  logic [TEN_W-1:0] cfg_tenure = '0;
  logic             txn_start = 1'b0;
  logic             data_done = 1'b0;
  logic             txn_end = 1'b0;
  logic             bus_own = 1'b0;
  logic             term_req;
  logic             lat_timeout;
  logic             tenure_exp;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_lat_watch #(.TEN_W(TEN_W)) i_pci_lat_watch (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_alt_tbl  (cfg_alt_tbl),
    .cfg_init_sel (cfg_init_sel),
    .cfg_sub_sel  (cfg_sub_sel),
    .cfg_tenure   (cfg_tenure),
    .txn_start    (txn_start),
    .data_done    (data_done),
    .txn_end      (txn_end),
    .bus_own      (bus_own),
    .term_req     (term_req),
    .lat_timeout  (lat_timeout),
    .tenure_exp   (tenure_exp)
  );

  // Expected initial limit in edges; 0 stands for "disabled" (R2, R3).
  function automatic int exp_init(input bit alt, input logic [1:0] sel);
    case ({alt, sel})
      3'b000: return 32;
      3'b001: return 16;
      3'b010: return 8;
      3'b011: return 4;
      3'b100: return 64;
      3'b101: return 128;
      3'b110: return 256;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_sub(input bit sel);
    return sel ? 4 : 8;
  endfunction

  function automatic int exp_ten(input int v);
    return (v / 8) * 8;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock; returns half a period after the rising edge.
  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/2);
  endtask

  task automatic scramble_cfg();
    cfg_alt_tbl  = 1'($urandom);
    cfg_init_sel = 2'($urandom);
    cfg_sub_sel  = 1'($urandom);
  endtask

  // One transaction; each phase waits a random delay that may overrun the limit.
  task automatic run_txn(input bit alt, input logic [1:0] isel, input bit ssel,
                         input int nph, input bit force_over);
    int  lim_i;
    int  lim_s;
    int  lim;
    int  d;
    bit  over;
    bit  done;
    string tag;
    cfg_alt_tbl  = alt;
    cfg_init_sel = isel;
    cfg_sub_sel  = ssel;
    txn_start    = 1'b1;
    tick();
    txn_start    = 1'b0;
    check("R6 flag cleared by start", int'(lat_timeout), 0);
    lim_i = exp_init(alt, isel);
    lim_s = exp_sub(ssel);
    done  = 1'b0;
    for (int p = 0; p < nph && !done; p++) begin
      lim = (p == 0) ? lim_i : lim_s;
      tag = (p == 0) ? (alt ? "R3" : "R2") : "R4";
      if (lim == 0) begin
        d    = force_over ? 280 : int'($urandom_range(280, 0));
        over = 1'b0;
      end else begin
        d    = force_over ? lim + 1 : int'($urandom_range(lim + 2, 0));
        over = (d >= lim);
      end
      if (!over) begin
        for (int k = 0; k < d; k++) begin
          scramble_cfg();
          tick();
          check({tag, " R8 no early terminate"}, int'(term_req), 0);
        end
        data_done = 1'b1;
        tick();
        data_done = 1'b0;
        check("R5 data phase restarts count", int'(term_req), 0);
      end else begin
        for (int k = 1; k <= lim; k++) begin
          scramble_cfg();
          tick();
          check({tag, " R8 terminate edge"}, int'(term_req), (k == lim) ? 1 : 0);
        end
        check("R6 timeout flag set", int'(lat_timeout), 1);
        tick();
        check("R6 single pulse", int'(term_req), 0);
        check("R6 flag held", int'(lat_timeout), 1);
        for (int k = 0; k < 10; k++) begin
          tick();
          check("R6 idle after terminate", int'(term_req), 0);
        end
        done = 1'b1;
      end
    end
    if (!done) begin
      txn_end = 1'b1;
      tick();
      txn_end = 1'b0;
      for (int k = 0; k < 12; k++) begin
        tick();
        check("R7 no terminate after end", int'(term_req), 0);
      end
    end
  endtask

  task automatic run_tenure(input int v, input int extra);
    int lim;
    cfg_tenure = TEN_W'(v);
    bus_own    = 1'b1;
    lim        = exp_ten(v);
    for (int k = 1; k <= lim + 1 + extra; k++) begin
      tick();
      cfg_tenure = TEN_W'($urandom);
      check("R9 tenure expiry", int'(tenure_exp), (k >= lim + 1) ? 1 : 0);
    end
    bus_own = 1'b0;
    tick();
    check("R10 tenure flag cleared", int'(tenure_exp), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD/2);
    rst_n   = 1'b0;
    bus_own = 1'b1;
    tick();
    tick();
    check("R1 reset term_req", int'(term_req), 0);
    check("R1 reset lat_timeout", int'(lat_timeout), 0);
    check("R1 reset tenure_exp", int'(tenure_exp), 0);
    bus_own = 1'b0;
    rst_n   = 1'b1;
    tick();
    check("R1 after reset term_req", int'(term_req), 0);
    check("R1 after reset tenure_exp", int'(tenure_exp), 0);

    // Directed: every initial code allowed to overrun (R2, R3).
    for (int c = 0; c < 8; c++)
      run_txn(c[2], c[1:0], 1'b0, 1, 1'b1);
    // Directed: both subsequent limits overrun after one data phase (R4).
    for (int s = 0; s < 2; s++) begin
      cfg_alt_tbl = 1'b0; cfg_init_sel = 2'b11; cfg_sub_sel = s[0];
      txn_start = 1'b1; tick(); txn_start = 1'b0;
      data_done = 1'b1; tick(); data_done = 1'b0;
      for (int k = 1; k <= exp_sub(s[0]); k++) begin
        scramble_cfg();
        tick();
        check("R4 subsequent terminate", int'(term_req), (k == exp_sub(s[0])) ? 1 : 0);
      end
    end

    // Directed R11: restart mid-transaction with a shorter limit.
    cfg_alt_tbl = 1'b0; cfg_init_sel = 2'b00; cfg_sub_sel = 1'b0;
    txn_start = 1'b1; tick(); txn_start = 1'b0;
    repeat (5) tick();
    cfg_init_sel = 2'b11;
    txn_start = 1'b1; txn_end = 1'b1; data_done = 1'b1;
    tick();
    txn_start = 1'b0; txn_end = 1'b0; data_done = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      check("R11 restart uses new limit", int'(term_req), (k == 4) ? 1 : 0);
    end

    // Random transactions.
    for (int t = 0; t < 60; t++)
      run_txn(1'($urandom), 2'($urandom), 1'($urandom),
              1 + int'($urandom_range(3, 0)), 1'b0);

    // Tenure timer: directed corners then random values.
    run_tenure(7, 3);
    run_tenure(8, 2);
    run_tenure(255, 4);
    for (int t = 0; t < 8; t++)
      run_tenure(int'($urandom_range(255, 0)), int'($urandom_range(4, 0)));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule